// File: doc/BRIEF.md
# Ethernet PHY Status LED Driver

This block turns a PHY's internal status into four LED drive signals: activity, link, 100 Mb/s speed and full duplex. Each status condition is registered once, so every LED follows its inputs one clock later. Carrier activity is lengthened by a pulse stretcher so that short bursts of traffic remain visible to a person. The stretch length is a count of reference-clock cycles. Its default matches 128 ms at 25 MHz, and a testbench can set it much shorter.

The board sets the polarity of each LED through strap pins that share the PHY address pins. The straps are captured only while reset is held. A strap of 1 makes the matching LED active-low, and a strap of 0 makes it active-high. During reset, every LED rests at the inactive level for its captured polarity.

The external reset is active-low. It asserts asynchronously and is released through a two-stage synchronizer. All status inputs are assumed to be synchronous to `clk_i`.

Top module: `phy_led_ctrl`

## Requirements
- R1: The LED index is fixed as follows: `led_o[0]` is activity, `led_o[1]` is link, `led_o[2]` is speed-100 and `led_o[3]` is full duplex. Each pin is driven with `led_o[i] = on[i] XOR strap[i]`, where `strap[i]` is the captured value of `strap_i[i]`.
- R2: `strap_i` is sampled on every clock while the internal reset is asserted. After reset is released, changes on `strap_i` do not affect `led_o`.
- R3: While reset is asserted, from the second clock edge onward, `led_o` equals the value applied to `strap_i`, which means every LED is inactive.
- R4: The activity LED is on in the cycle after carrier sense (`crs_i`) is sampled high.
- R5: After the last clock edge at which `crs_i` is high, the activity LED stays on for exactly `STRETCH_CYCLES` further edges. It then turns off.
- R6: If `crs_i` is high again at any edge while the stretch is running, the full stretch length restarts from that edge.
- R7: The link LED follows `link100_i` when `speed100_i` is 1. Otherwise it follows `link10_i`.
- R8: When `isolate_i` is low, the speed LED is on if `speed100_i` or `aneg_busy_i` is high, and off if both are low.
- R9: The speed LED is off whenever `isolate_i` is high, whatever the states of speed and auto-negotiation.
- R10: The full-duplex LED follows `fdx_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| strap_i | input | 4 | Polarity straps (address pins), one per LED |
| crs_i | input | 1 | Carrier sense |
| link10_i | input | 1 | Valid 10 Mb/s link |
| link100_i | input | 1 | Valid 100 Mb/s link |
| speed100_i | input | 1 | Internal speed selection: 1 = 100 Mb/s |
| aneg_busy_i | input | 1 | Auto-negotiation in progress |
| isolate_i | input | 1 | PHY isolated from its MII |
| fdx_i | input | 1 | Link is in full duplex |
| led_o | output | 4 | LED drive pins (activity, link, speed, duplex) |

## Verification
Two events can fall on the same clock edge: carrier sense coming back, and the stretch counter running out. The bench drives `crs_i` high again exactly on the edge where the activity LED would otherwise go dark. It also drives it high one edge later, and partway through a running stretch. A behavioural model tracks the cycle of the last carrier-sense sample and compares all four pins on every clock. A wrong restart therefore shows up as either a one-cycle dark gap or a stretch with the wrong length.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;

  localparam int unsigned LED_N    = 4;
  localparam int unsigned IDX_ACT  = 0;
  localparam int unsigned IDX_LINK = 1;
  localparam int unsigned IDX_SPD  = 2;
  localparam int unsigned IDX_FDX  = 3;

  typedef struct packed {
    logic crs;
    logic link10;
    logic link100;
    logic spd100;
    logic aneg_busy;
    logic isolate;
    logic fdx;
  } phy_stat_t;

endpackage

// File: rtl/led_rst_sync.sv
module led_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/led_stretch.sv
module led_stretch #(
  parameter int unsigned STRETCH_CYCLES = 3_200_000,
  localparam int unsigned CNT_W = $clog2(STRETCH_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             crs_i,
  output logic             act_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(STRETCH_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_busy;
  logic             cnt_en;

  assign cnt_busy = (cnt_q != '0);
  assign cnt_en   = crs_i | cnt_busy;

  // Next state: reload on carrier, otherwise count down to zero.
  always_comb begin
    cnt_d = cnt_q;
    if (crs_i) begin
      cnt_d = LOAD_VAL;
    end else if (cnt_busy) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign act_o = crs_i | cnt_busy;
  assign cnt_o = cnt_q;

endmodule

// File: rtl/led_state_map.sv
module led_state_map
  import phy_led_pkg::*;
(
  input  phy_stat_t        stat_i,
  input  logic             act_i,
  output logic [LED_N-1:0] on_d_o
);

  logic link_sel;
  logic spd_req;

  always_comb begin
    link_sel = stat_i.spd100 ? stat_i.link100 : stat_i.link10;
    spd_req  = (stat_i.spd100 | stat_i.aneg_busy) & ~stat_i.isolate;

    on_d_o           = '0;
    on_d_o[IDX_ACT]  = act_i;
    on_d_o[IDX_LINK] = link_sel;
    on_d_o[IDX_SPD]  = spd_req;
    on_d_o[IDX_FDX]  = stat_i.fdx;
  end

endmodule

// File: rtl/led_drive.sv
module led_drive #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] strap_i,
  input  logic [N-1:0] on_d_i,
  output logic [N-1:0] on_q_o,
  output logic [N-1:0] strap_q_o,
  output logic [N-1:0] led_o
);

  logic cap_en;

  assign cap_en = ~rst_ni;

  for (genvar i = 0; i < N; i++) begin : g_led
    logic strap_q;
    logic on_q;

    // Strap capture: enabled only while reset is held, no reset on the flop.
    always_ff @(posedge clk_i) begin
      if (cap_en) begin
        strap_q <= strap_i[i];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        on_q <= 1'b0;
      end else begin
        on_q <= on_d_i[i];
      end
    end

    assign strap_q_o[i] = strap_q;
    assign on_q_o[i]    = on_q;
    assign led_o[i]     = on_q ^ strap_q;
  end

endmodule

// File: rtl/phy_led_ctrl.sv
module phy_led_ctrl
  import phy_led_pkg::*;
#(
  parameter int unsigned STRETCH_CYCLES = 3_200_000,
  localparam int unsigned CNT_W = $clog2(STRETCH_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LED_N-1:0] strap_i,
  input  logic             crs_i,
  input  logic             link10_i,
  input  logic             link100_i,
  input  logic             speed100_i,
  input  logic             aneg_busy_i,
  input  logic             isolate_i,
  input  logic             fdx_i,
  output logic [LED_N-1:0] led_o
);

  logic             rst_sync_n;
  logic             act_req;
  logic [CNT_W-1:0] act_cnt;
  logic [LED_N-1:0] led_on_d;
  logic [LED_N-1:0] led_on;
  logic [LED_N-1:0] strap_q;
  phy_stat_t        stat;

  assign stat.crs       = crs_i;
  assign stat.link10    = link10_i;
  assign stat.link100   = link100_i;
  assign stat.spd100    = speed100_i;
  assign stat.aneg_busy = aneg_busy_i;
  assign stat.isolate   = isolate_i;
  assign stat.fdx       = fdx_i;

  led_rst_sync #(
    .STAGES(2)
  ) u_rst_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  led_stretch #(
    .STRETCH_CYCLES(STRETCH_CYCLES)
  ) u_stretch (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .crs_i (stat.crs),
    .act_o (act_req),
    .cnt_o (act_cnt)
  );

  led_state_map u_map (
    .stat_i(stat),
    .act_i (act_req),
    .on_d_o(led_on_d)
  );

  led_drive #(
    .N(LED_N)
  ) u_drive (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .strap_i  (strap_i),
    .on_d_i   (led_on_d),
    .on_q_o   (led_on),
    .strap_q_o(strap_q),
    .led_o    (led_o)
  );

endmodule

// File: rtl/phy_led_chk.sv
module phy_led_chk #(
  parameter int unsigned STRETCH_CYCLES = 3_200_000,
  localparam int unsigned CNT_W = $clog2(STRETCH_CYCLES + 1)
) (
  input logic             clk_i,
  input logic             rst_sync_n,
  input logic             crs_i,
  input logic             link10_i,
  input logic             link100_i,
  input logic             speed100_i,
  input logic             aneg_busy_i,
  input logic             isolate_i,
  input logic             fdx_i,
  input logic [3:0]       led_on,
  input logic [3:0]       strap_q,
  input logic [CNT_W-1:0] act_cnt
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(STRETCH_CYCLES);

  // R2
  strap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $past(rst_sync_n) |-> $stable(strap_q));

  // R4
  act_on_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    crs_i |=> led_on[0]);

  // R5
  act_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!crs_i && act_cnt == '0) |=> !led_on[0]);

  // R5
  cnt_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    act_cnt <= FULL);

  // R6
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    crs_i |=> act_cnt == FULL);

  // R7
  link_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    ((speed100_i && link100_i) || (!speed100_i && link10_i)) |=> led_on[1]);

  // R7
  link_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    ((speed100_i && !link100_i) || (!speed100_i && !link10_i)) |=> !led_on[1]);

  // R8
  spd_on_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!isolate_i && (speed100_i || aneg_busy_i)) |=> led_on[2]);

  // R9
  spd_iso_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    isolate_i |=> !led_on[2]);

  // R10
  fdx_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    fdx_i |=> led_on[3]);

endmodule

bind phy_led_ctrl phy_led_chk #(
  .STRETCH_CYCLES(STRETCH_CYCLES)
) u_chk (
  .clk_i      (clk_i),
  .rst_sync_n (rst_sync_n),
  .crs_i      (crs_i),
  .link10_i   (link10_i),
  .link100_i  (link100_i),
  .speed100_i (speed100_i),
  .aneg_busy_i(aneg_busy_i),
  .isolate_i  (isolate_i),
  .fdx_i      (fdx_i),
  .led_on     (led_on),
  .strap_q    (strap_q),
  .act_cnt    (act_cnt)
);

// File: tb/tb_phy_led_ctrl.sv
module tb_phy_led_ctrl;

  localparam int STR = 20;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] strap;
  logic       crs, l10, l100, s100, aneg, iso, fdx;
  logic [3:0] led;

  int         n_cmp = 0;
  int         n_bad = 0;
  bit         cmp_en = 1'b0;
  logic [3:0] strap_used;
  logic [3:0] exp_on = 4'b0;
  longint     cyc = 0;
  longint     last_crs = -1000000;
  string      phase = "init";

  always #4 clk = ~clk;

  phy_led_ctrl #(.STRETCH_CYCLES(STR)) dut (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(strap), .crs_i(crs),
    .link10_i(l10), .link100_i(l100), .speed100_i(s100),
    .aneg_busy_i(aneg), .isolate_i(iso), .fdx_i(fdx), .led_o(led)
  );

  // Behavioural reference: what each LED should show after this edge.
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!cmp_en) begin
      exp_on   <= 4'b0;
      last_crs = -1000000;
    end else begin
      if (crs === 1'b1) last_crs = cyc;
      exp_on[0] <= (cyc - last_crs) <= STR;                 // R4 R5 R6
      case ({s100, l100, l10})                                // R7
        3'b110, 3'b111, 3'b001, 3'b011: exp_on[1] <= 1'b1;
        default:                        exp_on[1] <= 1'b0;
      endcase
      if (iso) exp_on[2] <= 1'b0;                            // R9
      else     exp_on[2] <= (s100 || aneg);                  // R8
      exp_on[3] <= fdx;                                      // R10
    end
  end

  function automatic string bit_tag(int b);
    case (b)
      0: return "R5";
      1: return "R7";
      2: return "R8";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk) begin
    #2;
    if (cmp_en) begin
      n_cmp++;
      for (int b = 0; b < 4; b++) begin
        if (led[b] !== (exp_on[b] ^ strap_used[b])) begin
          n_bad++;
          $display("FAIL %s R1 phase=%s bit%0d cycle=%0d actual=%b expected=%b",
                   bit_tag(b), phase, b, cyc, led[b], exp_on[b] ^ strap_used[b]);
        end
      end
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_stat(logic c, logic a, logic b, logic s, logic g, logic i, logic f);
    crs = c; l10 = a; l100 = b; s100 = s; aneg = g; iso = i; fdx = f;
  endtask

  task automatic do_reset(logic [3:0] st);
    @(negedge clk);
    cmp_en = 1'b0;
    rst_n = 1'b0;
    strap = st;
    strap_used = st;
    set_stat(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);  // busy inputs: must not show
    step(4);
    n_cmp++;
    if (led !== st) begin
      n_bad++;
      $display("FAIL R3 in-reset level actual=%b expected=%b", led, st);
    end
    set_stat(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    step(5);
    strap = ~st;  // R2: must be ignored from now on
    step(1);
    cmp_en = 1'b1;
    step(2);
  endtask

  task automatic crs_burst(int hi, int lo);
    crs = 1'b1; step(hi);
    crs = 1'b0; step(lo);
  endtask

  initial begin
    rst_n = 1'b0;
    strap = 4'b1010;
    strap_used = 4'b1010;
    set_stat(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    do_reset(4'b1010);

    phase = "R10 duplex";
    fdx = 1'b1; step(3); fdx = 1'b0; step(2); fdx = 1'b1; step(1); fdx = 1'b0; step(2);

    phase = "R7 link select";
    for (int v = 0; v < 8; v++) begin
      {s100, l100, l10} = 3'(v);
      step(2);
    end

    phase = "R8 R9 speed";
    for (int v = 0; v < 8; v++) begin
      {s100, aneg, iso} = 3'(v);
      step(2);
    end
    set_stat(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    phase = "R4 R5 single pulse";
    crs_burst(1, STR + 5);

    phase = "R5 long carrier";
    crs_burst(7, STR + 4);

    phase = "R6 restart mid-stretch";
    crs_burst(1, 10);
    crs_burst(1, STR + 5);

    phase = "R6 re-rise on expiry edge";
    crs_burst(1, STR);
    crs_burst(1, STR + 1);
    crs_burst(1, STR + 4);

    phase = "R2 R1 mixed traffic";
    s100 = 1'b1; l100 = 1'b1; fdx = 1'b1;
    crs_burst(3, 4);
    iso = 1'b1; crs_burst(2, STR + 3);
    iso = 1'b0; aneg = 1'b1; s100 = 1'b0; l10 = 1'b1; step(3);

    do_reset(4'b0101);
    phase = "R1 second polarity";
    s100 = 1'b1; l100 = 1'b1; fdx = 1'b1;
    crs_burst(2, 5);
    iso = 1'b1; step(3);
    s100 = 1'b0; l10 = 1'b0; aneg = 1'b1; iso = 1'b0; crs_burst(1, STR + 3);
    fdx = 1'b0; step(3);

    cmp_en = 1'b0;
    step(1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule